// File: doc/BRIEF.md
# Sparse Gather Multiply-Accumulate Core

This block is the sparse-mode front end and arithmetic of one dot-product octet. A compressed row of the A operand keeps four non-zero values. Each of those values carries the index of the B row it multiplies. A fetch-index command loads the four indices into a dedicated offset register. An execute command then reads the four selected rows of B, in index-slot order, from an external row memory with one cycle of read latency. It stores them in an operand buffer and computes sixteen four-element dot products. Each product is added to a supplied C value and returned as one result vector.

There are two B operand buffers with an explicit life cycle (free, filling, ready, computing). While the dot-product units work on one buffer, the gather engine fills the other from the next execute. The two buffers trade roles only when the fill has finished and the current compute has drained. The stored A row is broadcast to all dot-product units. Each unit takes a different output column of the gathered rows. The sixteen columns are covered in several passes.

Top module: `sparse_gather_mac`

## Requirements
- R1: After reset, `out_valid`, `err` and `mem_rd` are low, and `cmd_ready` is high for both command kinds.
- R2: A fetch-index command (`cmd_op`=0) is accepted on `cmd_valid && cmd_ready`. It stores index slot k from `cmd_idx[k*IW +: IW]`, replacing any earlier indices, and those indices are used by every execute accepted afterwards.
- R3: An accepted execute (`cmd_op`=1) drives `mem_rd` for exactly four consecutive cycles, starting in the cycle after acceptance. `mem_addr` carries the stored indices of slots 0, 1, 2 and 3 in that order, and each row is taken from `mem_rdata` one cycle after its address.
- R4: For each column j, the result is `out_d[j*AW +: AW]` = `cmd_c[j*AW +: AW]` plus the sum over k of the signed product `cmd_a[k*DW +: DW]` × column j of gathered row k. Column j of a row is `mem_rdata[j*DW +: DW]`. The sum wraps modulo 2^AW, and the result is valid while `out_valid` is high.
- R5: An execute accepted before any fetch-index since reset raises `err` for exactly the next cycle, issues no memory read and produces no result.
- R6: The offset register is kept across executes, so several executes may reuse one fetch-index.
- R7: Every execute accepted after a fetch-index yields exactly one single-cycle `out_valid` pulse. Pulses come in acceptance order and are never in adjacent cycles.
- R8: When executes are offered back to back, the gather for one overlaps the compute of the previous one, so consecutive `out_valid` pulses are at most 6 cycles apart.
- R9: `cmd_ready` is low for an execute while the four reads of an earlier execute are still being issued. A fetch-index is always accepted, and new indices never alter the reads of an execute that was already accepted.
- R10: Indices may repeat within a row; a row selected twice is read twice and counts once per slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 1 | 0 = fetch-index, 1 = execute |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_idx | input | NNZ*IW | Row indices for fetch-index, slot k at bits k*IW |
| cmd_a | input | NNZ*DW | Compressed A row for execute, element k at bits k*DW |
| cmd_c | input | NCOL*AW | Accumulator inputs for execute, column j at bits j*AW |
| mem_rd | output | 1 | Row read strobe |
| mem_addr | output | IW | Row read address |
| mem_rdata | input | NCOL*DW | Row data, one cycle after the address |
| out_valid | output | 1 | Result pulse |
| out_d | output | NCOL*AW | Result vector, column j at bits j*AW |
| err | output | 1 | Execute issued with no indices loaded |

## Verification
The bench issues an execute straight out of reset. A design that ignored the missing indices would start reads or emit a result instead of one error pulse. It issues a fetch-index while a gather is still running. A design that re-read the live offset register would fetch the wrong rows for the execute already accepted. Extreme signed values (-128, 127) and a row of four identical indices expose sign-extension faults and any slot collapsing. A burst of back-to-back executes shows whether buffer swapping waits for both fill and compute, and whether the overlap keeps results within six cycles of each other without reordering them.

// File: rtl/sgm_pkg.sv
package sgm_pkg;
   typedef enum logic [1:0] {
      BUF_FREE  = 2'd0,
      BUF_FILL  = 2'd1,
      BUF_READY = 2'd2,
      BUF_COMP  = 2'd3
   } buf_state_e;

   localparam logic OP_FETCH = 1'b0;
   localparam logic OP_EXEC  = 1'b1;
endpackage

// File: rtl/sgm_fill_ctrl.sv
module sgm_fill_ctrl #(
   parameter int NNZ = 4,
   parameter int IW  = 4,
   localparam int SW = $clog2(NNZ)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              buf_i,
   input  logic [NNZ*IW-1:0] off_i,
   output logic              busy_o,
   output logic              rd_o,
   output logic [IW-1:0]     addr_o,
   output logic              wr_o,
   output logic              wr_buf_o,
   output logic [SW-1:0]     wr_slot_o,
   output logic              last_o
);
   localparam logic [SW-1:0] LAST = SW'(NNZ - 1);

   logic [NNZ*IW-1:0] off_q;
   logic [SW-1:0]     cnt_q, ps_q;
   logic              buf_q, busy_q, pv_q, pb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_q  <= '0;
         cnt_q  <= '0;
         buf_q  <= 1'b0;
         busy_q <= 1'b0;
         pv_q   <= 1'b0;
         ps_q   <= '0;
         pb_q   <= 1'b0;
      end else begin
         if (start_i) begin
            off_q  <= off_i;
            buf_q  <= buf_i;
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) busy_q <= 1'b0;
         end
         pv_q <= busy_q;
         ps_q <= cnt_q;
         pb_q <= buf_q;
      end
   end

   assign busy_o    = busy_q;
   assign rd_o      = busy_q;
   assign addr_o    = off_q[cnt_q*IW +: IW];
   assign wr_o      = pv_q;
   assign wr_buf_o  = pb_q;
   assign wr_slot_o = ps_q;
   assign last_o    = pv_q && (ps_q == LAST);

   // R9
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_q);
   // R3
   burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != LAST) |=> busy_q);
endmodule

// File: rtl/sgm_dp_unit.sv
module sgm_dp_unit #(
   parameter int NNZ = 4,
   parameter int DW  = 8,
   parameter int AW  = 32
) (
   input  logic [NNZ*DW-1:0] a_i,
   input  logic [NNZ*DW-1:0] b_i,
   input  logic [AW-1:0]     c_i,
   output logic [AW-1:0]     d_o
);
   logic signed [2*DW-1:0] prod;
   logic [AW-1:0]          acc;

   always_comb begin
      acc  = c_i;
      prod = '0;
      for (int k = 0; k < NNZ; k++) begin
         prod = $signed(a_i[k*DW +: DW]) * $signed(b_i[k*DW +: DW]);
         acc  = acc + {{(AW-2*DW){prod[2*DW-1]}}, prod};
      end
   end

   assign d_o = acc;
endmodule

// File: rtl/sparse_gather_mac.sv
module sparse_gather_mac
   import sgm_pkg::*;
#(
   parameter int NNZ   = 4,
   parameter int DW    = 8,
   parameter int AW    = 32,
   parameter int NCOL  = 16,
   parameter int NDP   = 4,
   parameter int KROWS = 16,
   localparam int IW    = $clog2(KROWS),
   localparam int RW    = NCOL * DW,
   localparam int NSTEP = NCOL / NDP,
   localparam int CW    = $clog2(NSTEP),
   localparam int SW    = $clog2(NNZ)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_op,
   output logic              cmd_ready,
   input  logic [NNZ*IW-1:0] cmd_idx,
   input  logic [NNZ*DW-1:0] cmd_a,
   input  logic [NCOL*AW-1:0] cmd_c,
   output logic              mem_rd,
   output logic [IW-1:0]     mem_addr,
   input  logic [RW-1:0]     mem_rdata,
   output logic              out_valid,
   output logic [NCOL*AW-1:0] out_d,
   output logic              err
);
   // elaboration-time parameter checks
   if (NCOL % NDP != 0) begin : g_bad_split
      $error("NCOL must be a multiple of NDP");
   end
   if (NSTEP < 2) begin : g_bad_steps
      $error("at least two compute passes are required");
   end
   if (AW <= 2 * DW) begin : g_bad_acc
      $error("accumulator must be wider than a product");
   end
   if (NNZ < 2 || (1 << SW) != NNZ) begin : g_bad_nnz
      $error("NNZ must be a power of two of at least 2");
   end
   if (KROWS < 2) begin : g_bad_rows
      $error("row memory needs at least two rows");
   end

   localparam logic [CW-1:0] CLAST = CW'(NSTEP - 1);

   // offset register and control state
   logic [NNZ*IW-1:0] off_q;
   logic              off_vld_q;
   buf_state_e        bst_q [2];
   logic              c_busy_q, cbuf_q, ov_q, err_q;
   logic [CW-1:0]     ccnt_q;

   // operand buffers (data only, no reset)
   logic [RW-1:0]      brow_q [2][NNZ];
   logic [NNZ*DW-1:0]  ba_q [2];
   logic [NCOL*AW-1:0] bc_q [2];
   logic [NCOL*AW-1:0] res_q;

   // gather engine wires
   logic          f_busy, f_wr, f_wbuf, f_last;
   logic [SW-1:0] f_wslot;

   logic exec_ok, acc_cmd, exec_go, exec_bad, fill_buf;
   logic rdy0, rdy1, comp_go, comp_buf;

   always_comb begin
      exec_ok   = !f_busy && (bst_q[0] == BUF_FREE || bst_q[1] == BUF_FREE);
      cmd_ready = (cmd_op == OP_FETCH) || exec_ok;
      acc_cmd   = cmd_valid && cmd_ready;
      exec_go   = acc_cmd && (cmd_op == OP_EXEC) && off_vld_q;
      exec_bad  = acc_cmd && (cmd_op == OP_EXEC) && !off_vld_q;
      fill_buf  = (bst_q[0] == BUF_FREE) ? 1'b0 : 1'b1;
      rdy0      = (bst_q[0] == BUF_READY);
      rdy1      = (bst_q[1] == BUF_READY);
      comp_go   = !c_busy_q && (rdy0 || rdy1);
      comp_buf  = rdy0 ? 1'b0 : 1'b1;
   end

   sgm_fill_ctrl #(.NNZ(NNZ), .IW(IW)) u_fill (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (exec_go),
      .buf_i     (fill_buf),
      .off_i     (off_q),
      .busy_o    (f_busy),
      .rd_o      (mem_rd),
      .addr_o    (mem_addr),
      .wr_o      (f_wr),
      .wr_buf_o  (f_wbuf),
      .wr_slot_o (f_wslot),
      .last_o    (f_last)
   );

   // dot-product units: shared A row, one output column each per pass
   logic [AW-1:0] dp_d [NDP];

   for (genvar u = 0; u < NDP; u++) begin : g_dp
      logic [NNZ*DW-1:0] b_v;
      logic [AW-1:0]     c_v;
      always_comb begin
         int col;
         col = int'(ccnt_q) * NDP + u;
         c_v = bc_q[cbuf_q][col*AW +: AW];
         b_v = '0;
         for (int k = 0; k < NNZ; k++) begin
            b_v[k*DW +: DW] = brow_q[cbuf_q][k][col*DW +: DW];
         end
      end
      sgm_dp_unit #(.NNZ(NNZ), .DW(DW), .AW(AW)) u_dp (
         .a_i (ba_q[cbuf_q]),
         .b_i (b_v),
         .c_i (c_v),
         .d_o (dp_d[u])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_q     <= '0;
         off_vld_q <= 1'b0;
         bst_q[0]  <= BUF_FREE;
         bst_q[1]  <= BUF_FREE;
         c_busy_q  <= 1'b0;
         cbuf_q    <= 1'b0;
         ccnt_q    <= '0;
         ov_q      <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         err_q <= exec_bad;
         ov_q  <= 1'b0;
         if (acc_cmd && cmd_op == OP_FETCH) begin
            off_q     <= cmd_idx;
            off_vld_q <= 1'b1;
         end
         if (exec_go) bst_q[fill_buf] <= BUF_FILL;
         if (f_last)  bst_q[f_wbuf]   <= BUF_READY;
         if (comp_go) begin
            bst_q[comp_buf] <= BUF_COMP;
            c_busy_q        <= 1'b1;
            cbuf_q          <= comp_buf;
            ccnt_q          <= '0;
         end else if (c_busy_q) begin
            ccnt_q <= ccnt_q + 1'b1;
            if (ccnt_q == CLAST) begin
               c_busy_q      <= 1'b0;
               bst_q[cbuf_q] <= BUF_FREE;
               ov_q          <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (exec_go) begin
         ba_q[fill_buf] <= cmd_a;
         bc_q[fill_buf] <= cmd_c;
      end
      if (f_wr) brow_q[f_wbuf][f_wslot] <= mem_rdata;
      if (c_busy_q) begin
         for (int u = 0; u < NDP; u++) begin
            res_q[(int'(ccnt_q)*NDP + u)*AW +: AW] <= dp_d[u];
         end
      end
   end

   assign out_valid = ov_q;
   assign out_d     = res_q;
   assign err       = err_q;

   // R7
   pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
   // R5
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!mem_rd && !out_valid));
   // R8
   one_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bst_q[0] == BUF_COMP, bst_q[1] == BUF_COMP}));
   // R8
   swap_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_busy_q && ccnt_q != CLAST) |=> (c_busy_q && $stable(cbuf_q)));
endmodule

// File: tb/sparse_gather_mac_tb.sv
`timescale 1ns/1ps
module sparse_gather_mac_tb;
   localparam int NNZ = 4, DW = 8, AW = 32, NCOL = 16, KROWS = 16, IW = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_op = 1'b1, cmd_ready;
   logic [NNZ*IW-1:0]  cmd_idx = '0;
   logic [NNZ*DW-1:0]  cmd_a = '0;
   logic [NCOL*AW-1:0] cmd_c = '0;
   logic mem_rd;
   logic [IW-1:0] mem_addr;
   logic [NCOL*DW-1:0] mem_rdata = '0;
   logic out_valid, err;
   logic [NCOL*AW-1:0] out_d;

   sparse_gather_mac u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_ready(cmd_ready), .cmd_idx(cmd_idx), .cmd_a(cmd_a), .cmd_c(cmd_c),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .out_valid(out_valid), .out_d(out_d), .err(err)
   );

   // row memory model, one-cycle latency
   logic [NCOL*DW-1:0] bmem [KROWS];
   always @(posedge clk) if (mem_rd) mem_rdata <= bmem[mem_addr];

   // reference model state
   int  m_off [NNZ];
   bit  m_vld = 0;
   bit  err_exp = 0;
   bit  mon_on = 0;
   bit  gap_on = 0;
   int  addr_q [$];
   logic [NCOL*AW-1:0] res_q [$];
   string res_tag = "R4";
   int  cyc = 0, last_out = -1, wd = 0;
   int  checks = 0, fails = 0;

   task automatic check(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [NCOL*AW-1:0] model_d(logic [NNZ*DW-1:0] a,
                                                  logic [NCOL*AW-1:0] c);
      logic [NCOL*AW-1:0] r;
      for (int j = 0; j < NCOL; j++) begin
         int s;
         s = $signed(c[j*AW +: AW]);
         for (int k = 0; k < NNZ; k++)
            s += $signed(a[k*DW +: DW]) * $signed(bmem[m_off[k]][j*DW +: DW]);
         r[j*AW +: AW] = s;
      end
      return r;
   endfunction

   function automatic logic [NCOL*AW-1:0] mk_c(int seed);
      logic [NCOL*AW-1:0] r;
      for (int j = 0; j < NCOL; j++) r[j*AW +: AW] = seed * 1000 - j * 77;
      return r;
   endfunction

   task automatic send(bit op, logic [NNZ*IW-1:0] idx, logic [NNZ*DW-1:0] a,
                       logic [NCOL*AW-1:0] c);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_a = a; cmd_c = c;
      #1;
      while (!cmd_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      if (op == 1'b0) begin
         for (int k = 0; k < NNZ; k++) m_off[k] = int'(idx[k*IW +: IW]);
         m_vld = 1;
      end else if (!m_vld) begin
         err_exp = 1;
      end else begin
         for (int k = 0; k < NNZ; k++) addr_q.push_back(m_off[k]);
         res_q.push_back(model_d(a, c));
      end
      #1 cmd_valid = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (res_q.size() == 0 && addr_q.size() == 0) break;
      end
      repeat (3) @(negedge clk);
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (mon_on) begin
         cyc++;
         check(err === err_exp, "R5 err", longint'(err), longint'(err_exp));
         err_exp = 0;
         if (mem_rd) begin
            if (addr_q.size() == 0) check(0, "R3 R5 unexpected read", 1, 0);
            else begin
               int e;
               e = addr_q.pop_front();
               check(int'(mem_addr) == e, "R3 R9 read address", longint'(mem_addr), e);
            end
         end
         if (out_valid) begin
            if (res_q.size() == 0) check(0, "R7 R5 unexpected result", 1, 0);
            else begin
               logic [NCOL*AW-1:0] e;
               e = res_q.pop_front();
               checks++;
               if (out_d !== e) begin
                  fails++;
                  $display("FAIL %s result: actual %h expected %h", res_tag, out_d, e);
               end
            end
            if (gap_on && last_out >= 0)
               check(cyc - last_out <= 6, "R8 result spacing", cyc - last_out, 6);
            last_out = cyc;
         end
      end
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 20000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected under 20000", wd);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < KROWS; r++)
         for (int j = 0; j < NCOL; j++)
            bmem[r][j*DW +: DW] = 8'(r * 37 + j * 11 + 5);

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      check(out_valid == 0, "R1 out_valid", longint'(out_valid), 0);
      check(err == 0,       "R1 err",       longint'(err), 0);
      check(mem_rd == 0,    "R1 mem_rd",    longint'(mem_rd), 0);
      check(cmd_ready == 1, "R1 ready exec", longint'(cmd_ready), 1);
      cmd_op = 1'b0; #1;
      check(cmd_ready == 1, "R1 ready fetch", longint'(cmd_ready), 1);
      mon_on = 1;

      // R5: execute with no indices loaded
      send(1'b1, '0, 32'h01020304, mk_c(1));
      drain();

      // R2 R4: first gather, extreme signed A values
      res_tag = "R2 R4";
      send(1'b0, {4'd12, 4'd7, 4'd0, 4'd3}, '0, '0);
      send(1'b1, '0, {8'h05, 8'hFD, 8'h7F, 8'h80}, mk_c(2));
      drain();

      // R6: reuse indices with new operands
      res_tag = "R6 R4";
      send(1'b1, '0, {8'h80, 8'h80, 8'h80, 8'h80}, mk_c(-3));
      drain();

      // R10: the same row in every slot
      res_tag = "R10 R4";
      send(1'b0, {4'd5, 4'd5, 4'd5, 4'd5}, '0, '0);
      send(1'b1, '0, {8'h7F, 8'h01, 8'hFF, 8'h10}, mk_c(4));
      drain();

      // R9: execute blocked during reads; fetch accepted and isolated
      res_tag = "R9 R4";
      send(1'b1, '0, {8'h02, 8'h03, 8'hF0, 8'h0A}, mk_c(5));
      @(negedge clk);
      cmd_op = 1'b1; #1;
      check(cmd_ready == 0, "R9 exec blocked during reads", longint'(cmd_ready), 0);
      cmd_op = 1'b0; #1;
      check(cmd_ready == 1, "R9 fetch accepted during reads", longint'(cmd_ready), 1);
      send(1'b0, {4'd15, 4'd1, 4'd9, 4'd14}, '0, '0);
      send(1'b1, '0, {8'hC0, 8'h3F, 8'h11, 8'hEE}, mk_c(6));
      drain();

      // R7 R8: back-to-back executes overlap gather and compute
      res_tag = "R7 R8 R4";
      gap_on = 1; last_out = -1;
      send(1'b0, {4'd2, 4'd11, 4'd6, 4'd13}, '0, '0);
      for (int i = 0; i < 4; i++)
         send(1'b1, '0, {8'(i * 9 + 1), 8'(-i - 2), 8'(i * 30), 8'h81}, mk_c(7 + i));
      drain();
      gap_on = 0;
      check(res_q.size() == 0, "R7 all results delivered", res_q.size(), 0);
      check(last_out >= 0, "R8 burst produced results", last_out, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule